// File: doc/BRIEF.md
# Open-Drain Bus Line Front End

This block connects a bus controller state machine to the two wired-AND lines of a two-wire serial bus, the clock line (SCL) and the data line (SDA). For each line the controller supplies a two-bit drive request. The block registers that request and turns it into three things: an output value that is always zero, an output enable that pulls the line low, and two pad-control status bits. The status bits tell the pad logic whether to engage a weak keeper or a stronger pull-up. The block never drives a line high. A high level comes only from releasing the line and letting the external pull-up raise it.

In the other direction, each sampled line level goes through a two-flop synchronizer into the system clock domain, and the clean levels go back to the controller. The block also watches the data line. It raises a one-cycle arbitration-loss pulse when it has released SDA but sees SDA low while SCL reads high. That pattern means another device is holding data low.

Top module: `bus_line_phy`

## Requirements
- R1: Each line's drive request uses the code 2'b00 = released with no pull-up, 2'b01 = released with keeper, 2'b10 = released with open-drain pull-up, 2'b11 = driven low. A request sampled at one rising clock edge takes effect at the outputs right after that edge and not before.
- R2: A line's output enable is 1 exactly when that line's registered request is 2'b11. SCL and SDA are controlled independently.
- R3: The output value pins `scl_o` and `sda_o` are always 0.
- R4: Any high-level request (2'b00, 2'b01, 2'b10) leaves the line's output enable at 0, so the line is in high impedance.
- R5: A line's keeper status is 1 only for code 2'b01, and its pull-up status is 1 only for code 2'b10. Both are 0 for codes 2'b00 and 2'b11.
- R6: A change on `scl_i` or `sda_i` shows on the matching synchronized output after exactly two rising clock edges.
- R7: The synchronizer flops reset to 1, so both synchronized outputs read 1 during reset and directly after it, whatever the line inputs are.
- R8: While reset is asserted, both lines are in the 2'b00 state: output enables 0 and all status bits 0.
- R9: `arb_lost_o` goes high for one cycle, one clock after the first cycle in which SDA is not requested low, the synchronized SDA is 0 and the synchronized SCL is 1. It stays low while that condition persists. It pulses again only after the condition has cleared and then returned.
- R10: `arb_lost_o` stays 0 while the block itself drives SDA low, and while the synchronized SCL is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_mode_i | input | 2 | SCL drive request code |
| sda_mode_i | input | 2 | SDA drive request code |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL output value, always 0 |
| scl_oe_o | output | 1 | SCL output enable; 1 pulls the line low |
| scl_keep_o | output | 1 | SCL keeper engage status |
| scl_pull_o | output | 1 | SCL open-drain pull-up engage status |
| sda_o | output | 1 | SDA output value, always 0 |
| sda_oe_o | output | 1 | SDA output enable; 1 pulls the line low |
| sda_keep_o | output | 1 | SDA keeper engage status |
| sda_pull_o | output | 1 | SDA open-drain pull-up engage status |
| scl_sync_o | output | 1 | SCL level synchronized to the system clock |
| sda_sync_o | output | 1 | SDA level synchronized to the system clock |
| arb_lost_o | output | 1 | One-cycle arbitration-loss pulse |

## Verification
A corrupted mode register shows up one edge later as a wrong output enable or status bit. The worst case is an enable during a high request, which would drive a line low when it should float. A synchronizer stage that is wrong, skipped or badly reset shows on the synchronized outputs either in the first cycles after reset or as a latency that is off by one edge. A wrong arbitration history bit shows one edge after the condition begins, as a missing pulse, a flag held high, or a flag raised while the block itself holds SDA low.

// File: rtl/bus_line_phy.sv
module bus_line_phy (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] scl_mode_i,
  input  logic [1:0] sda_mode_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       scl_oe_o,
  output logic       scl_keep_o,
  output logic       scl_pull_o,
  output logic       sda_o,
  output logic       sda_oe_o,
  output logic       sda_keep_o,
  output logic       sda_pull_o,
  output logic       scl_sync_o,
  output logic       sda_sync_o,
  output logic       arb_lost_o
);

  typedef enum logic [1:0] {
    LINE_HIZ  = 2'b00,
    LINE_KEEP = 2'b01,
    LINE_PULL = 2'b10,
    LINE_LOW  = 2'b11
  } line_mode_e;

  line_mode_e scl_mode_q, sda_mode_q;
  logic [1:0] scl_ff, sda_ff;
  logic       arb_cond, arb_seen_q, arb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_mode_q <= LINE_HIZ;
      sda_mode_q <= LINE_HIZ;
    end else begin
      scl_mode_q <= line_mode_e'(scl_mode_i);
      sda_mode_q <= line_mode_e'(sda_mode_i);
    end
  end

  assign scl_o      = 1'b0;
  assign sda_o      = 1'b0;
  assign scl_oe_o   = (scl_mode_q == LINE_LOW);
  assign sda_oe_o   = (sda_mode_q == LINE_LOW);
  assign scl_keep_o = (scl_mode_q == LINE_KEEP);
  assign sda_keep_o = (sda_mode_q == LINE_KEEP);
  assign scl_pull_o = (scl_mode_q == LINE_PULL);
  assign sda_pull_o = (sda_mode_q == LINE_PULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
    end
  end

  assign scl_sync_o = scl_ff[1];
  assign sda_sync_o = sda_ff[1];

  assign arb_cond = (sda_mode_q != LINE_LOW) & ~sda_ff[1] & scl_ff[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arb_seen_q <= 1'b0;
      arb_q      <= 1'b0;
    end else begin
      arb_seen_q <= arb_cond;
      arb_q      <= arb_cond & ~arb_seen_q;
    end
  end

  assign arb_lost_o = arb_q;

endmodule

// File: rtl/bus_line_phy_chk.sv
module bus_line_phy_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] scl_mode_i,
  input logic [1:0] sda_mode_i,
  input logic       scl_i,
  input logic       sda_i,
  input logic       scl_oe_o,
  input logic       scl_keep_o,
  input logic       scl_pull_o,
  input logic       sda_oe_o,
  input logic       sda_keep_o,
  input logic       sda_pull_o,
  input logic       scl_sync_o,
  input logic       sda_sync_o,
  input logic       arb_lost_o
);

  // R2
  scl_oe_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> $past(scl_mode_i) == 2'b11);

  // R2
  sda_oe_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> $past(sda_mode_i) == 2'b11);

  // R4
  sda_high_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_keep_o || sda_pull_o) |-> !sda_oe_o);

  // R5
  scl_status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_oe_o, scl_keep_o, scl_pull_o}));

  // R5
  sda_keep_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_keep_o |-> $past(sda_mode_i) == 2'b01);

  // R6
  scl_sync_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_sync_o) |-> $past(scl_i, 2) == 1'b0);

  // R6
  sda_sync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_sync_o) |-> $past(sda_i, 2) == 1'b1);

  // R9
  arb_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |-> ($past(scl_sync_o) && !$past(sda_sync_o) && !$past(sda_oe_o)));

  // R9
  arb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |=> !arb_lost_o);

endmodule

bind bus_line_phy bus_line_phy_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_mode_i (scl_mode_i),
  .sda_mode_i (sda_mode_i),
  .scl_i      (scl_i),
  .sda_i      (sda_i),
  .scl_oe_o   (scl_oe_o),
  .scl_keep_o (scl_keep_o),
  .scl_pull_o (scl_pull_o),
  .sda_oe_o   (sda_oe_o),
  .sda_keep_o (sda_keep_o),
  .sda_pull_o (sda_pull_o),
  .scl_sync_o (scl_sync_o),
  .sda_sync_o (sda_sync_o),
  .arb_lost_o (arb_lost_o)
);

// File: tb/bus_line_phy_test.sv
`timescale 1ns/1ps
module bus_line_phy_test;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] scl_mode = 2'b11, sda_mode = 2'b11;
  logic       scl_in = 1'b0, sda_in = 1'b0;
  logic       scl_o, scl_oe, scl_keep, scl_pull;
  logic       sda_o, sda_oe, sda_keep, sda_pull;
  logic       scl_sync, sda_sync, arb_lost;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_line_phy uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .scl_mode_i(scl_mode), .sda_mode_i(sda_mode),
    .scl_i(scl_in), .sda_i(sda_in),
    .scl_o(scl_o), .scl_oe_o(scl_oe), .scl_keep_o(scl_keep), .scl_pull_o(scl_pull),
    .sda_o(sda_o), .sda_oe_o(sda_oe), .sda_keep_o(sda_keep), .sda_pull_o(sda_pull),
    .scl_sync_o(scl_sync), .sda_sync_o(sda_sync), .arb_lost_o(arb_lost)
  );

  // {scl_mode, sda_mode, scl_oe, scl_keep, scl_pull, sda_oe, sda_keep, sda_pull}
  localparam int NVEC = 8;
  localparam logic [9:0] VEC [NVEC] = '{
    {2'b00, 2'b00, 6'b000_000},
    {2'b01, 2'b10, 6'b010_001},
    {2'b10, 2'b01, 6'b001_010},
    {2'b11, 2'b00, 6'b100_000},
    {2'b00, 2'b11, 6'b000_100},
    {2'b11, 2'b11, 6'b100_100},
    {2'b01, 2'b01, 6'b010_010},
    {2'b10, 2'b10, 6'b001_001}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    // R7 R8: reset with lines low and low-drive requested
    tick();
    tick();
    check("R8 enables in reset", {scl_oe, sda_oe}, 2'b00);
    check("R8 status in reset", {scl_keep, scl_pull, sda_keep, sda_pull}, 4'b0000);
    check("R7 sync in reset", {scl_sync, sda_sync}, 2'b11);
    check("R3 output values", {scl_o, sda_o}, 2'b00);
    check("R9 arb in reset", arb_lost, 1'b0);
    scl_mode = 2'b00;
    sda_mode = 2'b00;
    rst_ni = 1'b1;
    tick();
    check("R7 sync right after reset", {scl_sync, sda_sync}, 2'b11);
    scl_in = 1'b1;
    sda_in = 1'b1;
    tick();
    tick();

    // R1 R2 R4 R5: decode table
    for (int i = 0; i < NVEC; i++) begin
      scl_mode = VEC[i][9:8];
      sda_mode = VEC[i][7:6];
      tick();
      check("R1 R2 R4 R5 decode",
            {scl_oe, scl_keep, scl_pull, sda_oe, sda_keep, sda_pull}, VEC[i][5:0]);
      check("R3 output values", {scl_o, sda_o}, 2'b00);
    end

    // R1: request does not take effect before the clock edge
    scl_mode = 2'b00;
    sda_mode = 2'b00;
    tick();
    scl_mode = 2'b11;
    sda_mode = 2'b01;
    #1;
    check("R1 no early effect", {scl_oe, sda_keep}, 2'b00);
    tick();
    check("R1 effect after edge", {scl_oe, sda_keep}, 2'b11);
    scl_mode = 2'b00;
    sda_mode = 2'b00;
    tick();

    // R6: two-edge synchronizer latency
    scl_in = 1'b0;
    tick();
    check("R6 scl after one edge", scl_sync, 1'b1);
    tick();
    check("R6 scl after two edges", scl_sync, 1'b0);
    sda_in = 1'b0;
    tick();
    check("R6 sda after one edge", sda_sync, 1'b1);
    tick();
    check("R6 sda after two edges", sda_sync, 1'b0);
    scl_in = 1'b1;
    sda_in = 1'b1;
    tick();
    tick();
    check("R6 both back high", {scl_sync, sda_sync}, 2'b11);
    tick();

    // R9: arbitration loss pulse
    sda_in = 1'b0;
    tick();
    check("R9 no flag yet", arb_lost, 1'b0);
    tick();
    check("R9 no flag on condition cycle", arb_lost, 1'b0);
    tick();
    check("R9 pulse", arb_lost, 1'b1);
    tick();
    check("R9 single pulse", arb_lost, 1'b0);
    tick();
    check("R9 stays low while condition holds", arb_lost, 1'b0);
    sda_in = 1'b1;
    tick();
    tick();
    tick();
    check("R9 cleared", arb_lost, 1'b0);
    sda_in = 1'b0;
    tick();
    tick();
    tick();
    check("R9 second pulse", arb_lost, 1'b1);

    // R10: no flag while block drives SDA low
    sda_mode = 2'b11;
    tick();
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R10 sda driven low", arb_lost, 1'b0);
    end
    // R10: no flag while synchronized SCL is low
    scl_in = 1'b0;
    tick();
    tick();
    sda_mode = 2'b00;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R10 scl low", arb_lost, 1'b0);
    end

    // R8: reset mid-run returns to released state
    scl_mode = 2'b11;
    sda_mode = 2'b11;
    tick();
    check("R2 both driven", {scl_oe, sda_oe}, 2'b11);
    rst_ni = 1'b0;
    #1;
    check("R8 async reset releases lines", {scl_oe, sda_oe}, 2'b00);
    check("R7 async reset sets sync high", {scl_sync, sda_sync}, 2'b11);

    finish_run();
  end

endmodule